// File: doc/BRIEF.md
# Early-Warning Power-Fail Interrupt Pulser

This block warns a processor that its power is about to fail. It takes two digital flags. The first is a "monitored supply below sense point" flag from an external comparator that watches an upstream supply. The second is a "local supply good" flag. From these it produces an active-low non-maskable interrupt pulse. The sense flag must stay low without a break for a qualification time before a pulse is issued, so supply noise and short dips raise no interrupt. Each pulse has a fixed width, and that width is its guaranteed minimum. While the local supply is not good, warnings are held off.

Both flags first pass through a two-flop synchroniser. The qualification time and the pulse width are given in microseconds. They are converted to clock cycles from a clock-frequency parameter, which must be a whole number of MHz. A qualified event gives exactly one pulse. The block is armed again only after the sense flag has been back high for a full qualification time.

Top module: `pfail_nmi`

## Requirements
- R1: While rst_n is low, and in the first cycle after it is released, nmi_n is 1 (no interrupt).
- R2: When sense_low and vcc_ok are both 1 and stay 1, nmi_n goes to 0 exactly QUAL_CYC+2 clock cycles after the input change, where QUAL_CYC = (CLK_HZ/1000000)*QUAL_US. The 2 extra cycles come from the synchroniser.
- R3: Each interrupt holds nmi_n at 0 for exactly PULSE_CYC = (CLK_HZ/1000000)*PULSE_US cycles, then returns it to 1.
- R4: A sense_low assertion that lasts QUAL_CYC-1 cycles or less, with vcc_ok at 1, leaves nmi_n at 1.
- R5: While vcc_ok is 0, sense_low at 1 for any length of time leaves nmi_n at 1.
- R6: If sense_low is already 1 when vcc_ok rises, qualification starts from the rise of vcc_ok, and nmi_n falls QUAL_CYC+2 cycles after it.
- R7: If sense_low returns to 0 during a pulse, the pulse still lasts the full PULSE_CYC cycles.
- R8: Only one pulse is issued per qualified event. After a pulse the block re-arms only once sense_low has been 0 for QUAL_CYC consecutive synchronised cycles. A sense_low that stays 1, or that is released for a shorter time and then asserted again, issues no further pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| sense_low | input | 1 | 1 when the monitored supply is below its sense point (asynchronous) |
| vcc_ok | input | 1 | 1 when the local supply is above its trip level (asynchronous) |
| nmi_n | output | 1 | Active-low power-fail interrupt pulse |

## Verification
The hardest case to reach is the re-arm window. A second falling event must arrive after a pulse has ended but before the sense flag has been high for a full qualification time. To get there, the stimulus holds the sense flag low through the whole pulse, releases it for only a few cycles, and then pulls it low again. A later release that lasts long enough must bring firing back. The dip test uses exactly one cycle less than the qualification time, and the power-up test raises the supply-good flag while the sense flag is already low, so that each edge is hit exactly.

// File: rtl/pfail_nmi.sv
module pfail_nmi #(
  parameter int CLK_HZ   = 100_000_000,
  parameter int QUAL_US  = 5,
  parameter int PULSE_US = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sense_low,
  input  logic vcc_ok,
  output logic nmi_n
);
  localparam int CYC_PER_US = CLK_HZ / 1_000_000;
  localparam int QUAL_CYC   = CYC_PER_US * QUAL_US;
  localparam int PULSE_CYC  = CYC_PER_US * PULSE_US;
  localparam int MAX_CYC    = (QUAL_CYC > PULSE_CYC) ? QUAL_CYC : PULSE_CYC;
  localparam int CW         = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] QLAST = CW'(QUAL_CYC - 1);
  localparam logic [CW-1:0] PLAST = CW'(PULSE_CYC - 1);

  typedef enum logic [1:0] {ARMED, FIRING, REARM} st_t;

  logic [1:0] low_sync, ok_sync;
  logic s_low, s_ok, fault;
  logic [CW-1:0] cnt;
  st_t st;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      low_sync <= '0;
      ok_sync  <= '0;
    end else begin
      low_sync <= {low_sync[0], sense_low};
      ok_sync  <= {ok_sync[0], vcc_ok};
    end

  assign s_low = low_sync[1];
  assign s_ok  = ok_sync[1];
  assign fault = s_low & s_ok;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st  <= ARMED;
      cnt <= '0;
    end else begin
      case (st)
        ARMED:
          if (!fault)          cnt <= '0;
          else if (cnt == QLAST) begin st <= FIRING; cnt <= '0; end
          else                 cnt <= cnt + 1'b1;
        FIRING:
          if (cnt == PLAST)    begin st <= REARM; cnt <= '0; end
          else                 cnt <= cnt + 1'b1;
        REARM:
          if (s_low)           cnt <= '0;
          else if (cnt == QLAST) begin st <= ARMED; cnt <= '0; end
          else                 cnt <= cnt + 1'b1;
        default: begin st <= ARMED; cnt <= '0; end
      endcase
    end

  assign nmi_n = (st != FIRING);

  a_r2_fires_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nmi_n) |-> $past(fault));

  a_r3_holds_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!nmi_n && cnt != PLAST) |=> !nmi_n);

  a_r3_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (!nmi_n && cnt == PLAST) |=> nmi_n);

  a_r5_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_n && !s_ok) |=> nmi_n);

  a_r8_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_n) |=> nmi_n);

  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st != FIRING) |-> (cnt <= QLAST));

  initial a_r2_params: assert (QUAL_CYC >= 2 && PULSE_CYC >= 1);
endmodule

// File: tb/pfail_nmi_test.sv
module pfail_nmi_test;
  localparam int QC = 20;
  localparam int PC = 800;
  localparam int LAT = QC + 2;

  logic clk = 0, rst_n = 0, sense_low = 0, vcc_ok = 0;
  logic nmi_n;
  int cyc = 0, total = 0, bad = 0;
  bit done = 0;

  int    q_start[$];
  int    q_width[$];
  string q_tag[$];

  pfail_nmi #(.CLK_HZ(4_000_000), .QUAL_US(5), .PULSE_US(200)) uut (
    .clk(clk), .rst_n(rst_n), .sense_low(sense_low), .vcc_ok(vcc_ok), .nmi_n(nmi_n));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expect_pulse(input string req);
    q_start.push_back(cyc + LAT);
    q_width.push_back(PC);
    q_tag.push_back(req);
  endtask

  initial begin : monitor
    logic prev = 1;
    int st = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (prev && !nmi_n) st = cyc;
        if (!prev && nmi_n) begin
          if (q_start.size() == 0) check("R8 unexpected pulse", st, -1);
          else begin
            string t = q_tag.pop_front();
            check({t, " start"}, st, q_start.pop_front());
            check({t, " width R3"}, cyc - st, q_width.pop_front());
          end
        end
        prev = nmi_n;
      end
    end
  end

  initial begin : watchdog
    repeat (100_000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    wait_cyc(3);
    check("R1 in reset", nmi_n, 1);
    rst_n = 1;
    wait_cyc(1);
    check("R1 after reset", nmi_n, 1);
    vcc_ok = 1;
    wait_cyc(50);

    sense_low = 1; expect_pulse("R2");
    wait_cyc(1000);
    check("R8 held low no second pulse", nmi_n, 1);
    sense_low = 0; wait_cyc(10);
    sense_low = 1; wait_cyc(100);
    check("R8 short release no rearm", nmi_n, 1);
    sense_low = 0; wait_cyc(100);

    sense_low = 1; wait_cyc(QC - 1);
    sense_low = 0; wait_cyc(50);
    check("R4 dip of QUAL-1", nmi_n, 1);

    vcc_ok = 0; wait_cyc(10);
    sense_low = 1; wait_cyc(200);
    check("R5 gated while supply not good", nmi_n, 1);
    vcc_ok = 1; expect_pulse("R6");
    wait_cyc(LAT + 60);
    check("R7 pulse active", nmi_n, 0);
    sense_low = 0;
    wait_cyc(900);
    check("R7 pulse over", nmi_n, 1);

    sense_low = 1; expect_pulse("R8 rearmed");
    wait_cyc(900);
    sense_low = 0;
    wait_cyc(50);
    check("R8 queue drained", q_start.size(), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule